// File: doc/BRIEF.md
# Legacy I/O Window Decode Router

This block sits between a host bus and three downstream targets and settles, for every I/O cycle, which target serves it. Seven legacy address windows are grouped under five enable bits. When a window's bit is set, a cycle that falls inside that window is claimed and sent to an internal device port. When the bit is clear, or when no window matches, the cycle goes to an expansion bus. If the expansion bus ends the cycle with a master abort, the router issues the same cycle again on an ISA-style bus. If that bus stays silent for a bounded number of cycles, the router completes the request by itself.

The host side is a valid/ready request channel with a matching valid/ready response channel. Only one request is in flight at a time. `hst_ready` is high only while the router is idle. A response stays on `rsp_valid`, with its data and route code held steady, until the host takes it with `rsp_ready`. Each downstream request holds its valid, address and direction until that port's ready is seen. A downstream response counts only in a cycle after its request handshake. An 8-bit configuration write port loads the enable bits.

Top module: `io_decode_router`

## Requirements
- R1: After reset the enable bits are all 0, `hst_ready` is 1, and `rsp_valid`, `dev_req_valid`, `exp_req_valid` and `isa_req_valid` are 0.
- R2: A host request is accepted on a cycle where `hst_valid` and `hst_ready` are both 1. `hst_ready` stays 0 from acceptance until the response handshake, so only one request is outstanding.
- R3: Each enable bit covers its own windows. Bit 4 covers 0x170–0x177 and 0x376–0x377. Bit 3 covers 0x1F0–0x1F7 and 0x3F6–0x3F7. Bit 2 covers 0x278–0x27F. Bit 1 covers 0x378–0x37F. Bit 0 covers 0x3BC–0x3BF. An address one below or one above a window is not covered by it.
- R4: An access inside a window whose bit is 1 goes only to the internal device port. Its response has `rsp_route` = 0 and carries `dev_rsp_data`.
- R5: An access outside every enabled window goes to the expansion bus. If the expansion bus completes it without an abort, the response has `rsp_route` = 1 and carries `exp_rsp_data`.
- R6: A write to 0x377 or to 0x3F7 is never claimed and goes to the expansion bus. A read of either address follows its enable bit.
- R7: An expansion response with `exp_rsp_mabort` = 1 makes the router reissue the same address and direction on the ISA port. An ISA response gives `rsp_route` = 2 and carries `isa_rsp_data`.
- R8: If no ISA response arrives within TIMEOUT_CYC (16) cycles after the ISA request handshake, the request completes with `rsp_data` all ones and `rsp_route` = 3. A response in the 16th cycle still counts. A response arriving later is ignored.
- R9: A downstream request that is not yet accepted keeps its valid high and `dn_addr` and `dn_write` unchanged.
- R10: `rsp_valid`, `rsp_data` and `rsp_route` hold steady while `rsp_ready` is 0.
- R11: When `cfg_we` is 1, `cfg_wdata[4:0]` loads the enable bits, and bits 7:5 are ignored. The new value applies to requests accepted after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_valid | input | 1 | Host request valid |
| hst_ready | output | 1 | Router can accept a request |
| hst_addr | input | 16 | Host I/O address |
| hst_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Host response valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 8 | Read data, or all ones on timeout |
| rsp_route | output | 2 | 0 internal, 1 expansion, 2 ISA, 3 timeout |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write value |
| dn_addr | output | 16 | Address of the current downstream request |
| dn_write | output | 1 | Direction of the current downstream request |
| dev_req_valid | output | 1 | Internal device request valid |
| dev_req_ready | input | 1 | Internal device accepts the request |
| dev_rsp_valid | input | 1 | Internal device response valid |
| dev_rsp_data | input | 8 | Internal device response data |
| exp_req_valid | output | 1 | Expansion bus request valid |
| exp_req_ready | input | 1 | Expansion bus accepts the request |
| exp_rsp_valid | input | 1 | Expansion bus response valid |
| exp_rsp_mabort | input | 1 | Expansion cycle ended in master abort |
| exp_rsp_data | input | 8 | Expansion bus response data |
| isa_req_valid | output | 1 | ISA request valid |
| isa_req_ready | input | 1 | ISA bus accepts the request |
| isa_rsp_valid | input | 1 | ISA response valid |
| isa_rsp_data | input | 8 | ISA response data |

## Verification
The bench goes through all 32 enable settings and probes each window at one below, low, high and one above, for both reads and writes. A range comparison that is off by one would send an edge address to the wrong port. A wrong bit-to-window mapping would misroute an entire window. Writes and reads to 0x377 and 0x3F7 are compared directly. A decoder that excludes both directions, or neither, then gives the wrong route code. The abort fallback is tested with ISA replies that arrive early, in exactly the 16th cycle, one cycle late, and never. A timeout counter with an off-by-one error would turn a good reply into an all-ones completion, or take a stale one. Stalled expansion ready and held-back response ready check that nothing moves while a handshake is pending. Writes with only the top three configuration bits set check that reserved bits enable no window.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

  localparam int NWIN = 7;

  typedef enum logic [1:0] {
    RT_INT = 2'd0,
    RT_EXP = 2'd1,
    RT_ISA = 2'd2,
    RT_TMO = 2'd3
  } route_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_INT,
    S_EXP,
    S_ISA,
    S_DONE
  } rstate_e;

  // Lower bound of window i
  function automatic logic [15:0] win_lo(input int i);
    case (i)
      0: return 16'h0170;
      1: return 16'h0376;
      2: return 16'h01F0;
      3: return 16'h03F6;
      4: return 16'h0278;
      5: return 16'h0378;
      default: return 16'h03BC;
    endcase
  endfunction

  // Upper bound of window i (inclusive)
  function automatic logic [15:0] win_hi(input int i);
    case (i)
      0: return 16'h0177;
      1: return 16'h0377;
      2: return 16'h01F7;
      3: return 16'h03F7;
      4: return 16'h027F;
      5: return 16'h037F;
      default: return 16'h03BF;
    endcase
  endfunction

  // Enable bit that governs window i
  function automatic int win_bit(input int i);
    case (i)
      0, 1: return 4;
      2, 3: return 3;
      4: return 2;
      5: return 1;
      default: return 0;
    endcase
  endfunction

  // Window whose top address is never claimed on a write
  function automatic logic win_wr_excl(input int i);
    return (i == 1) || (i == 3);
  endfunction

endpackage

// File: rtl/io_route_cfg.sv
module io_route_cfg #(
  parameter int CFG_W = 8,
  parameter int EN_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [EN_W-1:0]  en
);

  logic unused_rsv;
  assign unused_rsv = ^wdata[CFG_W-1:EN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= wdata[EN_W-1:0];
  end

  a_r11_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> en == $past(wdata[EN_W-1:0]));

endmodule

// File: rtl/io_window_decode.sv
module io_window_decode
  import io_route_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EN_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [EN_W-1:0]   en,
  output logic              claim
);

  logic [NWIN-1:0] hit;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] LO  = ADDR_W'(win_lo(g));
    localparam logic [ADDR_W-1:0] HI  = ADDR_W'(win_hi(g));
    localparam int                BIT = win_bit(g);
    localparam logic              WRX = win_wr_excl(g);
    logic in_rng, blocked;
    assign in_rng  = (addr >= LO) && (addr <= HI);
    assign blocked = WRX && wr && (addr == HI);
    assign hit[g]  = in_rng && en[BIT] && !blocked;
  end

  assign claim = |hit;

  // R6: writes to the two guarded addresses are never claimed
  always_comb begin
    if (wr && ((addr == ADDR_W'(16'h0377)) || (addr == ADDR_W'(16'h03F7))))
      a_r6_wr_excl: assert (!claim);
  end

endmodule

// File: rtl/io_route_fsm.sv
module io_route_fsm
  import io_route_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_write,
  input  logic              claim,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_route,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic              dev_req_valid,
  input  logic              dev_req_ready,
  input  logic              dev_rsp_valid,
  input  logic [DATA_W-1:0] dev_rsp_data,
  output logic              exp_req_valid,
  input  logic              exp_req_ready,
  input  logic              exp_rsp_valid,
  input  logic              exp_rsp_mabort,
  input  logic [DATA_W-1:0] exp_rsp_data,
  output logic              isa_req_valid,
  input  logic              isa_req_ready,
  input  logic              isa_rsp_valid,
  input  logic [DATA_W-1:0] isa_rsp_data
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  rstate_e           state;
  logic              sent;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] data_q;
  route_e            route_q;

  assign hst_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_DONE);
  assign rsp_data      = data_q;
  assign rsp_route     = route_q;
  assign dn_addr       = addr_q;
  assign dn_write      = wr_q;
  assign dev_req_valid = (state == S_INT) && !sent;
  assign exp_req_valid = (state == S_EXP) && !sent;
  assign isa_req_valid = (state == S_ISA) && !sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sent    <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      data_q  <= '0;
      route_q <= RT_INT;
    end else begin
      case (state)
        S_IDLE: if (hst_valid) begin
          addr_q <= hst_addr;
          wr_q   <= hst_write;
          sent   <= 1'b0;
          state  <= claim ? S_INT : S_EXP;
        end
        S_INT: begin
          if (!sent) begin
            if (dev_req_ready) sent <= 1'b1;
          end else if (dev_rsp_valid) begin
            data_q  <= dev_rsp_data;
            route_q <= RT_INT;
            state   <= S_DONE;
          end
        end
        S_EXP: begin
          if (!sent) begin
            if (exp_req_ready) sent <= 1'b1;
          end else if (exp_rsp_valid) begin
            if (exp_rsp_mabort) begin
              sent  <= 1'b0;
              state <= S_ISA;
            end else begin
              data_q  <= exp_rsp_data;
              route_q <= RT_EXP;
              state   <= S_DONE;
            end
          end
        end
        S_ISA: begin
          if (!sent) begin
            if (isa_req_ready) begin
              sent <= 1'b1;
              cnt  <= '0;
            end
          end else if (isa_rsp_valid) begin
            data_q  <= isa_rsp_data;
            route_q <= RT_ISA;
            state   <= S_DONE;
          end else if (cnt == CNT_LAST) begin
            data_q  <= '1;
            route_q <= RT_TMO;
            state   <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DONE: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_req_valid, exp_req_valid, isa_req_valid}));

  a_r2_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && hst_ready) |=> !hst_ready);

  a_r9_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_valid && !dev_req_ready) |=> dev_req_valid && $stable(dn_addr) && $stable(dn_write));

  a_r9_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_req_valid && !exp_req_ready) |=> exp_req_valid && $stable(dn_addr) && $stable(dn_write));

  a_r9_isa_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_req_valid && !isa_req_ready) |=> isa_req_valid && $stable(dn_addr) && $stable(dn_write));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data) && $stable(rsp_route));

  a_r7_isa_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isa_req_valid) |-> $past(exp_rsp_valid && exp_rsp_mabort));

  a_r8_timeout_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ISA && sent && !isa_rsp_valid && cnt == CNT_LAST)
      |=> rsp_valid && (rsp_data == '1) && (rsp_route == RT_TMO));

endmodule

// File: rtl/io_decode_router.sv
module io_decode_router #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 8,
  parameter int EN_W        = 5,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_route,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  output logic              dev_req_valid,
  input  logic              dev_req_ready,
  input  logic              dev_rsp_valid,
  input  logic [DATA_W-1:0] dev_rsp_data,
  output logic              exp_req_valid,
  input  logic              exp_req_ready,
  input  logic              exp_rsp_valid,
  input  logic              exp_rsp_mabort,
  input  logic [DATA_W-1:0] exp_rsp_data,
  output logic              isa_req_valid,
  input  logic              isa_req_ready,
  input  logic              isa_rsp_valid,
  input  logic [DATA_W-1:0] isa_rsp_data
);

  logic [EN_W-1:0] en;
  logic            claim;

  io_route_cfg #(.CFG_W(CFG_W), .EN_W(EN_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .en(en)
  );

  io_window_decode #(.ADDR_W(ADDR_W), .EN_W(EN_W)) dec_i (
    .addr(hst_addr), .wr(hst_write), .en(en), .claim(claim)
  );

  io_route_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_addr(hst_addr), .hst_write(hst_write),
    .claim(claim),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_route(rsp_route),
    .dn_addr(dn_addr), .dn_write(dn_write),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_data(dev_rsp_data),
    .exp_req_valid(exp_req_valid), .exp_req_ready(exp_req_ready),
    .exp_rsp_valid(exp_rsp_valid), .exp_rsp_mabort(exp_rsp_mabort), .exp_rsp_data(exp_rsp_data),
    .isa_req_valid(isa_req_valid), .isa_req_ready(isa_req_ready),
    .isa_rsp_valid(isa_rsp_valid), .isa_rsp_data(isa_rsp_data)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> hst_ready && !rsp_valid);

endmodule

// File: tb/io_decode_router_tb_top.sv
`timescale 1ns/1ps
module io_decode_router_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        hst_valid = 0, hst_write = 0, rsp_ready = 0, cfg_we = 0;
  logic [15:0] hst_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        hst_ready, rsp_valid, dn_write;
  logic [7:0]  rsp_data;
  logic [1:0]  rsp_route;
  logic [15:0] dn_addr;
  logic        dev_req_valid, exp_req_valid, isa_req_valid;
  logic        dev_req_ready = 1, dev_rsp_valid = 0;
  logic        exp_req_ready = 0, exp_rsp_valid = 0, exp_rsp_mabort = 0;
  logic        isa_req_ready = 1, isa_rsp_valid = 0;
  logic [7:0]  dev_rsp_data = 0, exp_rsp_data = 0, isa_rsp_data = 0;

  io_decode_router dut_i (.*);

  typedef struct packed { logic [1:0] rt; logic [7:0] d; logic [15:0] a; logic w; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int abort_mode = 0, isa_delay = 1, exp_wait = 1, bp_cycles = 0;
  logic [7:0] cfg_m = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [1:0] ref_route(input logic [15:0] a, input bit w, input logic [7:0] c);
    bit pos = 0;
    if (c[4] && ((a >= 16'h170 && a <= 16'h177) || (a == 16'h376) || (a == 16'h377 && !w))) pos = 1;
    if (c[3] && ((a >= 16'h1F0 && a <= 16'h1F7) || (a == 16'h3F6) || (a == 16'h3F7 && !w))) pos = 1;
    if (c[2] && a >= 16'h278 && a <= 16'h27F) pos = 1;
    if (c[1] && a >= 16'h378 && a <= 16'h37F) pos = 1;
    if (c[0] && a >= 16'h3BC && a <= 16'h3BF) pos = 1;
    if (pos) return 2'd0;
    if (abort_mode == 0) return 2'd1;
    if (isa_delay == 0 || isa_delay > 16) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [7:0] port_data(input logic [15:0] a, input bit w, input logic [1:0] rt);
    case (rt)
      2'd0: return a[7:0] ^ 8'h5A ^ {7'b0, w};
      2'd1: return a[7:0] ^ 8'hA5 ^ {7'b0, w};
      2'd2: return a[7:0] ^ 8'h3C ^ {7'b0, w};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    cfg_m = {3'b000, v[4:0]};
  endtask

  task automatic send(input logic [15:0] a, input bit w);
    exp_t e;
    @(negedge clk);
    while (!hst_ready) @(negedge clk);
    e.a = a; e.w = w;
    e.rt = ref_route(a, w, cfg_m);
    e.d = port_data(a, w, e.rt);
    q.push_back(e);
    hst_valid = 1; hst_addr = a; hst_write = w;
    @(negedge clk);
    hst_valid = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Internal device responder: always ready, replies one cycle after handshake
  initial forever begin
    @(negedge clk);
    if (dev_req_valid) begin
      logic [15:0] a; logic w;
      a = dn_addr; w = dn_write;
      @(negedge clk);
      dev_rsp_valid = 1; dev_rsp_data = a[7:0] ^ 8'h5A ^ {7'b0, w};
      @(negedge clk);
      dev_rsp_valid = 0;
    end
  end

  // Expansion responder: delays ready, checks request holds (R9)
  initial forever begin
    @(negedge clk);
    if (exp_req_valid) begin
      logic [15:0] a; logic w;
      a = dn_addr; w = dn_write;
      for (int k = 0; k < exp_wait; k++) begin
        @(negedge clk);
        check(exp_req_valid && dn_addr == a && dn_write == w, "R9", "exp request held",
              {15'b0, exp_req_valid, dn_addr}, {16'h1, a});
      end
      exp_req_ready = 1;
      @(negedge clk);
      exp_req_ready = 0;
      exp_rsp_valid = 1; exp_rsp_mabort = (abort_mode != 0);
      exp_rsp_data = a[7:0] ^ 8'hA5 ^ {7'b0, w};
      @(negedge clk);
      exp_rsp_valid = 0; exp_rsp_mabort = 0;
    end
  end

  // ISA responder: replies isa_delay cycles after handshake, 0 = never
  initial forever begin
    @(negedge clk);
    if (isa_req_valid) begin
      logic [15:0] a; logic w; int dl;
      a = dn_addr; w = dn_write; dl = isa_delay;
      if (dl != 0) begin
        repeat (dl) @(negedge clk);
        isa_rsp_valid = 1; isa_rsp_data = a[7:0] ^ 8'h3C ^ {7'b0, w};
        @(negedge clk);
        isa_rsp_valid = 0;
      end
    end
  end

  // Monitor / scoreboard
  initial forever begin
    @(negedge clk);
    rsp_ready = 0;
    if (rsp_valid) begin
      logic [7:0] d0; logic [1:0] r0;
      d0 = rsp_data; r0 = rsp_route;
      check(!hst_ready, "R2", "hst_ready low while response pending", {31'b0, hst_ready}, 0);
      for (int k = 0; k < bp_cycles; k++) begin
        @(negedge clk);
        check(rsp_valid && rsp_data == d0 && rsp_route == r0, "R10", "response held",
              {22'b0, rsp_valid, rsp_route, rsp_data}, {22'b0, 1'b1, r0, d0});
      end
      if (q.size() == 0) begin
        check(0, "R2", "unexpected response", {24'b0, rsp_data}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_route == e.rt && rsp_data == e.d,
              (e.rt == 2'd0) ? "R4" : (e.rt == 2'd1) ? "R5" : (e.rt == 2'd2) ? "R7" : "R8",
              $sformatf("addr %0h wr %0d route/data", e.a, e.w),
              {22'b0, rsp_route, rsp_data}, {22'b0, e.rt, e.d});
      end
      rsp_ready = 1;
      @(negedge clk);
      rsp_ready = 0;
    end
  end

  function automatic logic [15:0] edge_addr(input int i);
    case (i)
      0: return 16'h170; 1: return 16'h177; 2: return 16'h376; 3: return 16'h377;
      4: return 16'h1F0; 5: return 16'h1F7; 6: return 16'h3F6; 7: return 16'h3F7;
      8: return 16'h278; 9: return 16'h27F; 10: return 16'h378; 11: return 16'h37F;
      12: return 16'h3BC; default: return 16'h3BF;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(hst_ready == 1, "R1", "hst_ready after reset", {31'b0, hst_ready}, 1);
    check(!rsp_valid && !dev_req_valid && !exp_req_valid && !isa_req_valid, "R1", "no valid after reset",
          {28'b0, rsp_valid, dev_req_valid, exp_req_valid, isa_req_valid}, 0);
    send(16'h1F0, 0);  // R1: enables start cleared -> expansion

    // R3 R4 R5 R6: every enable setting, every window edge +/-1, read and write
    for (int c = 0; c < 32; c++) begin
      cfg_write(c[7:0]);
      for (int i = 0; i < 14; i++) begin
        for (int dlt = -1; dlt <= 1; dlt += 2) begin
          logic [15:0] a;
          a = edge_addr(i) + ((i % 2 == 0) ? ((dlt < 0) ? 16'hFFFF : 16'h0) : ((dlt < 0) ? 16'h0 : 16'h1));
          send(a, 0);
          send(a, 1);
        end
      end
    end

    // R6: write exclusions with everything enabled
    cfg_write(8'h1F);
    send(16'h377, 1); send(16'h377, 0); send(16'h3F7, 1); send(16'h3F7, 0);

    // R11: reserved bits enable nothing; fresh value applies next request
    cfg_write(8'hE0);
    send(16'h170, 0); send(16'h3BC, 1);
    cfg_write(8'h08);
    send(16'h1F3, 1);

    // R7: master abort falls back to ISA
    cfg_write(8'h00);
    abort_mode = 1; isa_delay = 3;
    send(16'h1F0, 0); send(16'h2F8, 1);
    // R8: timeout boundaries
    isa_delay = 16; send(16'h378, 0);
    isa_delay = 17; send(16'h379, 0);
    repeat (4) @(negedge clk);
    check(!rsp_valid && hst_ready, "R8", "late ISA reply ignored", {30'b0, rsp_valid, hst_ready}, 1);
    isa_delay = 0; send(16'h0080, 1);
    abort_mode = 0; isa_delay = 1;

    // R9 R10: stalls on both sides
    exp_wait = 4; bp_cycles = 3;
    send(16'h0060, 0); send(16'h3BD, 1);
    cfg_write(8'h01);
    send(16'h3BE, 0);
    exp_wait = 1; bp_cycles = 0;

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule